// File: doc/BRIEF.md
# Glitch-Free Double-Buffered PWM Timer

This block is an 8-bit timer/counter that drives a single pulse-width-modulated pin. It counts in one of two shapes: a single-slope sawtooth that runs from zero to full scale and wraps, or a dual-slope triangle that climbs to full scale and then falls back to zero. Each count step happens only on a clock cycle where the `tick` input is high, so an external prescaler sets the rate.

Software sets the duty cycle by writing a compare value. That write lands in a holding register. The compare register that actually drives the pin copies it only at the top of the count, so a duty change never cuts a pulse short or adds a spurious edge. A 2-bit pin-mode field picks one of three pin behaviours: the pin is off, the pulse is non-inverted, or the pulse is inverted. At the two extreme compare values, the pin settles to a fixed level as the requirements below describe.

Two sticky flags are set by the count: one at the turnaround or wrap, and one on a compare match. Each flag drives its own interrupt line, gated by a per-flag enable and by a global enable input. Four small registers give the interface: compare, control, flags, and a read-only view of the count.

Top module: `dbl_pwm_timer`

## Requirements
- R1: A write to address 0 loads only the holding register. The active compare register takes the holding value on a tick cycle where the count is 255, and at no other time. In dual-slope mode this is the top turnaround. In single-slope mode it is the wrap.
- R2: A read of address 0 returns the holding register, that is, the most recently written compare value, even before it reaches the active register.
- R3: The count changes only on cycles where `tick` is high. Control bit 2 selects the mode.
  - With bit 2 = 0 (single-slope), the count steps up by one and wraps from 255 to 0.
  - With bit 2 = 1 (dual-slope), the count climbs to 255 and then steps down to 254. It falls to 0 and then steps up to 1.
  - Address 3 reads the count.
- R4: The overflow flag (flag bit 0) and the compare flag (flag bit 1) are set on a tick cycle as follows:
  - In dual-slope mode, the overflow flag is set when the count is 0.
  - In single-slope mode, the overflow flag is set when the count is 255.
  - In both modes, the compare flag is set when the count equals the active compare value.
- R5: Dual-slope pin behaviour, with pin-mode bits = control[1:0]:
  - With mode 10, a match on a rising step drives the pin low, and a match on a falling step drives it high. The step at count 0 is rising and the step at count 255 is falling.
  - With mode 11, the pin levels are the reverse of mode 10.
  - As a result, compare 0 holds the pin low under mode 10 and high under mode 11. Compare 255 holds it high under mode 10 and low under mode 11.
  - The pin changes one clock after the tick.
- R6: Single-slope pin behaviour:
  - With mode 10, the wrap tick drives the pin high and a match tick drives it low, with the wrap winning when both occur. Mode 11 inverts this.
  - Compare 255 therefore holds the pin at a constant level.
  - Compare 0 gives a pulse one tick long in every period.
- R7: Pin modes 00 and 01 drive the pin low within one clock, whatever the count does.
- R8: Writing 1 to a bit at address 2 clears that flag. A flag being set in the same cycle wins over the clear. Writing 0 has no effect. Control is at address 1, and reads back bits [4:0] with the upper bits as zero.
- R9: The interrupt outputs follow the flags directly:
  - `irq_ovf` is high exactly when the overflow flag, control bit 3 and `gie` are all set.
  - `irq_cmp` is high exactly when the compare flag, control bit 4 and `gie` are all set.
- R10: Reset clears the count, the direction, both compare registers, control, both flags and the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for this cycle |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 compare, 1 control, 2 flags) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 to 3) |
| rd_data | output | 8 | Combinational read data |
| pwm_out | output | 1 | PWM pin |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |

## Verification
A bad direction bit or a bad count shows on the count read port within one cycle. It also moves the match point, so the pin edges shift within the same period. If the active compare register latched at the wrong moment, the pin edge would move before the top of the count; the bench model catches this at the first mismatched cycle, as early as one clock after the write. A wrong flag or output-mode decision is caught on the next clock through `irq_ovf`, `irq_cmp`, the flag read, or the pin level, because the reference model compares every port on every clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic [1:0] {
      SEL_CMP  = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_FLAG = 2'd2,
      SEL_CNT  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic       cmp_ie;
      logic       ovf_ie;
      logic       dual;
      logic [1:0] pin_mode;
   } ctrl_t;

   localparam int CTRL_W   = $bits(ctrl_t);
   localparam int FLAG_OVF = 0;
   localparam int FLAG_CMP = 1;
   localparam int NFLAG    = 2;

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   input  logic         dual,
   output logic [W-1:0] cnt,
   output logic         up_step,
   output logic         at_top,
   output logic         at_bot
);
   localparam logic [W-1:0] TOP = '1;

   logic dir_dn;

   assign at_top  = (cnt == TOP);
   assign at_bot  = (cnt == '0);
   assign up_step = dual ? ((!dir_dn && !at_top) || (dir_dn && at_bot)) : 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         dir_dn <= 1'b0;
      end else if (tick) begin
         if (up_step) begin
            cnt    <= cnt + 1'b1;
            dir_dn <= 1'b0;
         end else begin
            cnt    <= cnt - 1'b1;
            dir_dn <= 1'b1;
         end
      end
   end

   AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt)); // R3
   AST_DUAL_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
      (tick && dual) |=> ((cnt == W'($past(cnt) + 1'b1)) || (cnt == W'($past(cnt) - 1'b1)))); // R3

endmodule

// File: rtl/pwm_cmp_buf.sv
module pwm_cmp_buf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         latch,
   output logic [W-1:0] hold,
   output logic [W-1:0] act
);

   always_ff @(posedge clk) begin
      if (rst) begin
         hold <= '0;
         act  <= '0;
      end else begin
         if (wr)    hold <= wdata;
         if (latch) act  <= hold;
      end
   end

   AST_ACTIVE_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (rst)
      !latch |=> $stable(act)); // R1

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       dual,
   input  logic [1:0] pin_mode,
   input  logic       match,
   input  logic       up_step,
   input  logic       at_top,
   output logic       pwm
);

   always_ff @(posedge clk) begin
      if (rst) begin
         pwm <= 1'b0;
      end else if (!pin_mode[1]) begin
         pwm <= 1'b0;
      end else if (tick) begin
         if (dual) begin
            if (match) pwm <= up_step ? pin_mode[0] : ~pin_mode[0];
         end else begin
            if (at_top)     pwm <= ~pin_mode[0];
            else if (match) pwm <= pin_mode[0];
         end
      end
   end

   AST_PIN_OFF: assert property (@(posedge clk) disable iff (rst)
      !pin_mode[1] |=> !pwm); // R7
   AST_PIN_WAITS_TICK: assert property (@(posedge clk) disable iff (rst)
      (pin_mode[1] && !tick) |=> $stable(pwm)); // R5

endmodule

// File: rtl/pwm_flags.sv
module pwm_flags #(
   parameter int NF = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NF-1:0] set,
   input  logic          clr_wr,
   input  logic [NF-1:0] clr_mask,
   output logic [NF-1:0] flag
);

   for (genvar gi = 0; gi < NF; gi++) begin : g_flag
      always_ff @(posedge clk) begin
         if (rst)                              flag[gi] <= 1'b0;
         else if (set[gi])                     flag[gi] <= 1'b1;
         else if (clr_wr && clr_mask[gi])      flag[gi] <= 1'b0;
      end

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
         (flag[gi] && !(clr_wr && clr_mask[gi])) |=> flag[gi]); // R8
      AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
         set[gi] |=> flag[gi]); // R4
   end

endmodule

// File: rtl/dbl_pwm_timer.sv
module dbl_pwm_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   input  logic         gie,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic [1:0]   rd_addr,
   output logic [W-1:0] rd_data,
   output logic         pwm_out,
   output logic         irq_ovf,
   output logic         irq_cmp
);
   import pwm_pkg::*;

   if (W < CTRL_W) begin : g_bad_width
      $error("dbl_pwm_timer: W must hold the control field");
   end

   ctrl_t            ctrl;
   logic [W-1:0]     cnt, hold, act;
   logic             up_step, at_top, at_bot, match, latch;
   logic [NFLAG-1:0] flags, flag_set;
   logic             wr_cmp, wr_ctrl, wr_flag;

   assign wr_cmp  = wr_en && (reg_sel_e'(wr_addr) == SEL_CMP);
   assign wr_ctrl = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
   assign wr_flag = wr_en && (reg_sel_e'(wr_addr) == SEL_FLAG);

   always_ff @(posedge clk) begin
      if (rst)          ctrl <= '0;
      else if (wr_ctrl) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   pwm_counter #(.W(W)) u_cnt (
      .clk(clk), .rst(rst), .tick(tick), .dual(ctrl.dual),
      .cnt(cnt), .up_step(up_step), .at_top(at_top), .at_bot(at_bot)
   );

   assign latch = tick && at_top;
   assign match = (cnt == act);

   pwm_cmp_buf #(.W(W)) u_buf (
      .clk(clk), .rst(rst), .wr(wr_cmp), .wdata(wr_data),
      .latch(latch), .hold(hold), .act(act)
   );

   pwm_wave u_wave (
      .clk(clk), .rst(rst), .tick(tick), .dual(ctrl.dual),
      .pin_mode(ctrl.pin_mode), .match(match), .up_step(up_step),
      .at_top(at_top), .pwm(pwm_out)
   );

   assign flag_set[FLAG_OVF] = tick && (ctrl.dual ? at_bot : at_top);
   assign flag_set[FLAG_CMP] = tick && match;

   pwm_flags #(.NF(NFLAG)) u_flags (
      .clk(clk), .rst(rst), .set(flag_set), .clr_wr(wr_flag),
      .clr_mask(wr_data[NFLAG-1:0]), .flag(flags)
   );

   assign irq_ovf = flags[FLAG_OVF] && ctrl.ovf_ie && gie;
   assign irq_cmp = flags[FLAG_CMP] && ctrl.cmp_ie && gie;

   always_comb begin
      case (reg_sel_e'(rd_addr))
         SEL_CMP:  rd_data = hold;
         SEL_CTRL: rd_data = W'(ctrl);
         SEL_FLAG: rd_data = W'(flags);
         default:  rd_data = cnt;
      endcase
   end

   AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[FLAG_OVF]) |-> $past(tick)); // R4

endmodule

// File: tb/dbl_pwm_timer_test.sv
module dbl_pwm_timer_test;
   logic       clk = 1'b0;
   logic       rst, tick, gie, wr_en;
   logic [1:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data;
   logic       pwm_out, irq_ovf, irq_cmp;

   always #10 clk = ~clk;

   dbl_pwm_timer #(.W(8)) uut (
      .clk(clk), .rst(rst), .tick(tick), .gie(gie), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .pwm_out(pwm_out), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
   );

   int n_run = 0, n_fail = 0;
   int m_cnt = 0, m_dn = 0, m_hold = 0, m_act = 0, m_ctrl = 0, m_fo = 0, m_fc = 0, m_out = 0;
   bit rand_tick = 0;
   logic [15:0] lfsr = 16'hACE1;

   // behavioural reference model
   always @(posedge clk) begin : model
      int om, dual, top, match, upst, so, sc;
      int n_cnt, n_dn, n_act, n_out;
      if (rst) begin
         m_cnt = 0; m_dn = 0; m_hold = 0; m_act = 0; m_ctrl = 0; m_fo = 0; m_fc = 0; m_out = 0;
      end else begin
         om = m_ctrl & 3; dual = (m_ctrl >> 2) & 1;
         top = (m_cnt == 255); match = (m_cnt == m_act);
         upst = dual ? ((m_dn == 0 && !top) || (m_dn == 1 && m_cnt == 0)) : 1;
         n_cnt = m_cnt; n_dn = m_dn; n_act = m_act; n_out = m_out;
         so = 0; sc = 0;
         if (tick) begin
            if (om >= 2) begin
               if (dual) begin
                  if (match) n_out = upst ? (om & 1) : 1 - (om & 1);
               end else begin
                  if (top) n_out = 1 - (om & 1);
                  else if (match) n_out = om & 1;
               end
            end
            so = dual ? (m_cnt == 0) : top;
            sc = match;
            if (top) n_act = m_hold;
            if (upst) begin n_cnt = (m_cnt + 1) % 256; n_dn = 0; end
            else begin n_cnt = m_cnt - 1; n_dn = 1; end
         end
         if (om < 2) n_out = 0;
         if (wr_en && wr_addr == 0) m_hold = wr_data;
         if (wr_en && wr_addr == 1) m_ctrl = wr_data & 31;
         if (wr_en && wr_addr == 2) begin
            if (wr_data[0]) m_fo = 0;
            if (wr_data[1]) m_fc = 0;
         end
         if (so) m_fo = 1;
         if (sc) m_fc = 1;
         m_cnt = n_cnt; m_dn = n_dn; m_act = n_act; m_out = n_out;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_rd(input logic [1:0] a);
      case (a)
         2'd0: return m_hold;
         2'd1: return m_ctrl;
         2'd2: return m_fo | (m_fc << 1);
         default: return m_cnt;
      endcase
   endfunction

   task automatic compare_all();
      int eo, ec;
      string ptag, rtag;
      eo = m_fo & ((m_ctrl >> 3) & 1) & gie;
      ec = m_fc & ((m_ctrl >> 4) & 1) & gie;
      ptag = ((m_ctrl & 3) < 2) ? "R7 pin" : (((m_ctrl >> 2) & 1) ? "R5 pin" : "R6 pin");
      case (rd_addr)
         2'd0: rtag = "R2 cmp read";
         2'd1: rtag = "R8 ctrl read";
         2'd2: rtag = "R4 flag read";
         default: rtag = "R3 count read";
      endcase
      chk(pwm_out == m_out[0], ptag, pwm_out, m_out);
      chk(irq_ovf == eo[0], "R9 irq_ovf", irq_ovf, eo);
      chk(irq_cmp == ec[0], "R9 irq_cmp", irq_cmp, ec);
      chk(rd_data == exp_rd(rd_addr), rtag, rd_data, exp_rd(rd_addr));
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (rand_tick) tick = lfsr[0];
         rd_addr = rd_addr + 2'd1;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      cyc(1);
      wr_en = 1'b0;
   endtask

   task automatic count_level(input int n, input bit lvl, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         cyc(1);
         if (pwm_out == lvl) c++;
      end
   endtask

   initial begin
      int c;
      rst = 1'b1; tick = 1'b0; gie = 1'b1; wr_en = 1'b0;
      wr_addr = '0; wr_data = '0; rd_addr = '0;
      cyc(3);
      rst = 1'b0;
      // R10: everything cleared
      for (int a = 0; a < 4; a++) begin
         rd_addr = 2'(a); #1;
         chk(rd_data == 8'd0, "R10 reset register", rd_data, 0);
      end
      chk(pwm_out == 1'b0, "R10 reset pin", pwm_out, 0);

      // single-slope, mode 10, both interrupt enables
      wr(1, 8'h1A);
      wr(0, 8'h40);
      tick = 1'b1;
      cyc(300);
      wr(0, 8'h80);
      rd_addr = 2'd0; #1;
      chk(rd_data == 8'h80, "R2 holding read-back", rd_data, 8'h80);  // R1 latch checked by model
      cyc(600);

      // R8 clear flags with tick off
      tick = 1'b0;
      wr(2, 8'h03);
      rd_addr = 2'd2; #1;
      chk(rd_data == 8'd0, "R8 write-one clear", rd_data, 0);
      chk(irq_ovf == 1'b0 && irq_cmp == 1'b0, "R9 no request after clear", irq_ovf, 0);
      cyc(20);
      tick = 1'b1;
      gie = 1'b0;
      cyc(400);
      gie = 1'b1;

      // R6 extremes in single-slope mode
      wr(0, 8'hFF);
      cyc(300);
      count_level(300, 1'b0, c);
      chk(c == 0, "R6 compare 255 holds high (mode 10)", c, 0);
      wr(0, 8'h00);
      cyc(300);
      count_level(512, 1'b1, c);
      chk(c == 2, "R6 compare 0 one-tick pulse", c, 2);
      wr(1, 8'h1B);
      wr(0, 8'hFF);
      cyc(300);
      count_level(300, 1'b1, c);
      chk(c == 0, "R6 compare 255 holds low (mode 11)", c, 0);
      wr(0, 8'h40);
      cyc(600);

      // R5 extremes in dual-slope mode
      wr(1, 8'h1E);
      wr(0, 8'h00);
      cyc(1100);
      count_level(520, 1'b1, c);
      chk(c == 0, "R5 compare 0 low (mode 10)", c, 0);
      wr(0, 8'hFF);
      cyc(1100);
      count_level(520, 1'b0, c);
      chk(c == 0, "R5 compare 255 high (mode 10)", c, 0);
      wr(1, 8'h1F);
      cyc(1100);
      count_level(520, 1'b1, c);
      chk(c == 0, "R5 compare 255 low (mode 11)", c, 0);
      wr(0, 8'h00);
      cyc(1100);
      count_level(520, 1'b0, c);
      chk(c == 0, "R5 compare 0 high (mode 11)", c, 0);

      // R3 gated ticks with a mid-range duty, both modes
      rand_tick = 1'b1;
      wr(1, 8'h1E);
      wr(0, 8'h80);
      cyc(3000);
      wr(0, 8'h30);
      cyc(1500);
      wr(1, 8'h1A);
      cyc(1500);
      rand_tick = 1'b0;
      tick = 1'b1;

      // R7 pin modes 00 and 01
      wr(1, 8'h1C);
      count_level(400, 1'b1, c);
      chk(c == 0, "R7 mode 00 low", c, 0);
      wr(1, 8'h19);
      count_level(400, 1'b1, c);
      chk(c == 0, "R7 mode 01 low", c, 0);

      // R10 reset mid-run
      rst = 1'b1;
      cyc(2);
      rst = 1'b0;
      rd_addr = 2'd3; #1;
      chk(rd_data == 8'd0, "R10 count cleared", rd_data, 0);
      cyc(50);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule